// File: doc/BRIEF.md
# Binary64 Floating-Point Multiplier

This block multiplies two IEEE-754 binary64 operands and returns the correctly rounded binary64 product together with five exception flags. It handles zeros, infinities, quiet and signalling NaNs, and subnormal values on both the inputs and the output. The significand product is formed with a plain multiply. The result then passes through a single normalise-and-round stage. An optional output register gives the block a fixed latency of one cycle.

The rounding direction for each operation is chosen at the inputs. If the per-operation override is enabled and the second operand was read from a register, the mode carried with the operation is used. In every other case the mode from the global control field applies. The flags describe only the current result. Accumulating them into a sticky status word, and any trapping, is left to the surrounding logic.

Flag vector layout: bit 0 invalid, bit 1 denormal operand, bit 2 overflow, bit 3 underflow, bit 4 inexact.

Top module: `fp_mul64`

## Requirements
- R1: For finite operands, `result` is the exact product rounded to binary64 in the selected mode. Under mode 00 it matches a round-to-nearest-even double multiply bit for bit.
- R2: The mode is `op_rm` when `rm_override_en` and `b_from_reg` are both 1, and `csr_rm` otherwise. Encoding: 00 nearest-even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero.
- R3: Directed modes round the magnitude up or down according to the mode and the result sign. Any discarded nonzero bit sets inexact (flag bit 4).
- R4: When the rounded magnitude exceeds the largest finite value, overflow (bit 2) and inexact are set. The result is infinity for mode 00, for mode 10 with a positive sign, and for mode 01 with a negative sign. Otherwise it is the largest finite value of that sign.
- R5: Results below the normal range are returned as correctly rounded subnormals or zero. Underflow (bit 3) is set when the unbounded exponent is below the normal range before rounding and the result is inexact. Exact tiny results raise no underflow.
- R6: Zero times infinity returns 0xFFF8000000000000 and sets invalid (bit 0). A signalling NaN operand sets invalid and is returned with its top fraction bit forced to 1. A quiet NaN operand raises no invalid.
- R7: Except for NaN results, the result sign is the XOR of the operand signs, including zero and infinity results.
- R8: Denormal (bit 1) is set whenever either operand has a zero exponent field and a nonzero fraction.
- R9: `out_valid` rises exactly one cycle after `in_valid`. `result` and `flags` hold their values in cycles without `in_valid`.
- R10: While `rst_n` is low, `out_valid`, `result` and `flags` are all zero.
- R11: When both operands are NaN, the quieted first operand is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 64 | First operand, binary64 |
| op_b | input | 64 | Second operand, binary64 |
| csr_rm | input | 2 | Global rounding mode |
| rm_override_en | input | 1 | Per-operation rounding override requested |
| op_rm | input | 2 | Rounding mode carried with the operation |
| b_from_reg | input | 1 | Second operand was read from a register |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Rounded product, binary64 |
| flags | output | 5 | Exception flags for this result |

## Verification
A wrong normalisation shift or exponent offset shows up immediately in `result` on the very next valid cycle. It appears as a product off by a power of two or a misplaced subnormal, and hundreds of random normal and near-underflow vectors compared against a real-number multiply expose it. A rounding increment applied on the wrong condition moves only the last fraction bit. It surfaces on the directed half-ulp, tie and overflow vectors in every mode. Misclassified special operands show as a wrong NaN payload, a wrong sign or a missing invalid or denormal flag in the same cycle the result appears.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_DOWN = 2'b01,
      RM_UP   = 2'b10,
      RM_ZERO = 2'b11
   } rmode_e;

   localparam int FLAG_W = 5;
   localparam int FL_INV = 0;
   localparam int FL_DEN = 1;
   localparam int FL_OVF = 2;
   localparam int FL_UNF = 3;
   localparam int FL_INX = 4;

   typedef struct packed {
      logic is_zero;
      logic is_inf;
      logic is_nan;
      logic is_snan;
      logic is_sub;
   } fclass_t;

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
   import fpm_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] op,
   output logic                  sign,
   output logic [EXP_W-1:0]      exp_eff,
   output logic [FRAC_W:0]       sig,
   output fclass_t               cls
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_zero, exp_ones, frac_zero;

   assign sign      = op[EXP_W+FRAC_W];
   assign exp_f     = op[EXP_W+FRAC_W-1 -: EXP_W];
   assign frac_f    = op[FRAC_W-1:0];
   assign exp_zero  = (exp_f == '0);
   assign exp_ones  = &exp_f;
   assign frac_zero = (frac_f == '0);

   // subnormals use the minimum exponent with no hidden bit
   assign exp_eff = exp_zero ? EXP_W'(1) : exp_f;
   assign sig     = {~exp_zero, frac_f};

   assign cls.is_zero = exp_zero & frac_zero;
   assign cls.is_sub  = exp_zero & ~frac_zero;
   assign cls.is_inf  = exp_ones & frac_zero;
   assign cls.is_nan  = exp_ones & ~frac_zero;
   assign cls.is_snan = exp_ones & ~frac_zero & ~frac_f[FRAC_W-1];
endmodule

// File: rtl/fpm_lzc.sv
module fpm_lzc #(
   parameter int W = 106,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  d,
   output logic [CW-1:0] cnt
);
   always_comb begin
      cnt = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (d[i]) cnt = CW'(W - 1 - i);
      end
   end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
   import fpm_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic                          sign,
   input  logic signed [EXP_W+2:0]       be,
   input  logic [2*FRAC_W+1:0]           norm,
   input  rmode_e                        rm,
   output logic [EXP_W+FRAC_W-1:0]       mag,
   output logic                          ovf,
   output logic                          unf,
   output logic                          inx
);
   localparam int M    = FRAC_W + 1;
   localparam int PW   = 2 * M;
   localparam int EMAX = (1 << EXP_W) - 1;
   localparam int MAGW = EXP_W + FRAC_W;

   logic            tiny, lost, guard, sticky, inc, big, to_inf;
   int              sh;
   logic [PW-1:0]   shifted, lost_mask;
   logic [M-1:0]    mant;
   logic [EXP_W-1:0] exp_f;
   logic [MAGW-1:0] packed_v, sum;

   always_comb begin
      tiny = (be < 1);
      sh   = 0;
      if (tiny) sh = ((1 - int'(be)) > PW + 1) ? PW + 1 : (1 - int'(be));
      // denormalising shift, remembering every bit pushed out
      lost_mask = ~({PW{1'b1}} << sh);
      lost      = |(norm & lost_mask);
      shifted   = norm >> sh;
      mant      = shifted[PW-1 -: M];
      guard     = shifted[PW-1-M];
      sticky    = lost | (|shifted[PW-2-M:0]);
      exp_f     = tiny ? '0 : be[EXP_W-1:0];
      // a carry out of the fraction lands in the exponent field
      packed_v  = {exp_f, mant[FRAC_W-1:0]};
      case (rm)
         RM_NEAR: inc = guard & (sticky | mant[0]);
         RM_UP:   inc = ~sign & (guard | sticky);
         RM_DOWN: inc = sign & (guard | sticky);
         default: inc = 1'b0;
      endcase
      sum    = packed_v + MAGW'(inc);
      big    = (int'(be) >= EMAX) || (&sum[MAGW-1 -: EXP_W]);
      to_inf = (rm == RM_NEAR) | ((rm == RM_UP) & ~sign) | ((rm == RM_DOWN) & sign);
      ovf    = big;
      unf    = tiny & (guard | sticky);
      inx    = guard | sticky | big;
      if (big)
         mag = to_inf ? {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                      : {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      else
         mag = sum;
   end
endmodule

// File: rtl/fp_mul64.sv
module fp_mul64
   import fpm_pkg::*;
#(
   parameter int EXP_W   = 11,
   parameter int FRAC_W  = 52,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [EXP_W+FRAC_W:0]     op_a,
   input  logic [EXP_W+FRAC_W:0]     op_b,
   input  logic [1:0]                csr_rm,
   input  logic                      rm_override_en,
   input  logic [1:0]                op_rm,
   input  logic                      b_from_reg,
   output logic                      out_valid,
   output logic [EXP_W+FRAC_W:0]     result,
   output logic [FLAG_W-1:0]         flags
);
   localparam int W    = 1 + EXP_W + FRAC_W;
   localparam int M    = FRAC_W + 1;
   localparam int PW   = 2 * M;
   localparam int LZ_W = $clog2(PW + 1);
   localparam int EW   = EXP_W + 3;
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;

   if (EXP_W < 4 || EXP_W > 15 || FRAC_W < 4) begin : g_bad_fmt
      $error("fp_mul64: unsupported format widths");
   end

   rmode_e            rm_sel;
   logic              sgn_a, sgn_b, sgn_r;
   logic [EXP_W-1:0]  ex_a, ex_b;
   logic [M-1:0]      sg_a, sg_b;
   fclass_t           cl_a, cl_b;
   logic [PW-1:0]     prod, norm;
   logic [LZ_W-1:0]   lz;
   logic signed [EW-1:0] be;
   logic [W-2:0]      rnd_mag;
   logic              rnd_ovf, rnd_unf, rnd_inx;
   logic              any_nan, zi_inv, any_snan, den;
   logic [W-1:0]      res_c;
   logic [FLAG_W-1:0] flags_c;

   // override applies only to register-sourced second operands
   assign rm_sel = rmode_e'((rm_override_en && b_from_reg) ? op_rm : csr_rm);

   fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
      .op(op_a), .sign(sgn_a), .exp_eff(ex_a), .sig(sg_a), .cls(cl_a));
   fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
      .op(op_b), .sign(sgn_b), .exp_eff(ex_b), .sig(sg_b), .cls(cl_b));

   assign prod = sg_a * sg_b;

   fpm_lzc #(.W(PW), .CW(LZ_W)) u_lzc (.d(prod), .cnt(lz));

   assign norm = prod << lz;
   assign be   = EW'(int'(ex_a) + int'(ex_b) - BIAS + 1 - int'(lz));

   fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
      .sign(sgn_r), .be(be), .norm(norm), .rm(rm_sel),
      .mag(rnd_mag), .ovf(rnd_ovf), .unf(rnd_unf), .inx(rnd_inx));

   function automatic logic [W-1:0] quieten(input logic [W-1:0] v);
      logic [W-1:0] q;
      q = v;
      q[FRAC_W-1] = 1'b1;
      return q;
   endfunction

   assign sgn_r    = sgn_a ^ sgn_b;
   assign any_nan  = cl_a.is_nan | cl_b.is_nan;
   assign any_snan = cl_a.is_snan | cl_b.is_snan;
   assign zi_inv   = (cl_a.is_zero & cl_b.is_inf) | (cl_a.is_inf & cl_b.is_zero);
   assign den      = cl_a.is_sub | cl_b.is_sub;

   always_comb begin
      flags_c         = '0;
      flags_c[FL_DEN] = den;
      if (any_nan) begin
         res_c           = cl_a.is_nan ? quieten(op_a) : quieten(op_b);
         flags_c[FL_INV] = any_snan;
      end else if (zi_inv) begin
         res_c           = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
         flags_c[FL_INV] = 1'b1;
      end else if (cl_a.is_inf | cl_b.is_inf) begin
         res_c = {sgn_r, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (cl_a.is_zero | cl_b.is_zero) begin
         res_c = {sgn_r, {(W-1){1'b0}}};
      end else begin
         res_c           = {sgn_r, rnd_mag};
         flags_c[FL_OVF] = rnd_ovf;
         flags_c[FL_UNF] = rnd_unf;
         flags_c[FL_INX] = rnd_inx;
      end
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags     <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result <= res_c;
               flags  <= flags_c;
            end
         end
      end

      p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(result) && $stable(flags)));
      p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !any_nan && !zi_inv) |=> (result[W-1] == $past(op_a[W-1] ^ op_b[W-1])));
      p_den_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && den) |=> flags[FL_DEN]);
   end else begin : g_out_comb
      assign out_valid = in_valid;
      assign result    = res_c;
      assign flags     = flags_c;
   end

   p_no_overflow_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && flags[FL_OVF]) |-> flags[FL_INX]);
   p_unf_inexact_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && flags[FL_UNF]) |-> flags[FL_INX]);
   p_inv_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && flags[FL_INV]) |-> ((&result[W-2 -: EXP_W]) && result[FRAC_W-1]));
   p_ovf_mag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && flags[FL_OVF]) |-> (result[W-2 -: EXP_W] >= EXP_W'((1 << EXP_W) - 2)));
endmodule

// File: tb/fp_mul64_tb.sv
`timescale 1ns/1ps
module fp_mul64_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] op_a = '0, op_b = '0;
   logic [1:0]  csr_rm = 2'b00, op_rm = 2'b00;
   logic        rm_override_en = 1'b0, b_from_reg = 1'b0;
   logic        out_valid;
   logic [63:0] result;
   logic [4:0]  flags;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   fp_mul64 u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .csr_rm(csr_rm), .rm_override_en(rm_override_en), .op_rm(op_rm),
      .b_from_reg(b_from_reg), .out_valid(out_valid), .result(result), .flags(flags));

   typedef struct packed {
      logic [63:0] a;
      logic [63:0] b;
      logic [1:0]  csr;
      logic        ovr;
      logic [1:0]  orm;
      logic        breg;
      logic [63:0] exp_res;
      logic [4:0]  exp_fl;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VECS [NV] = '{
      // R1 exact normal products
      '{64'h4008000000000000, 64'h3FE0000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'h3FF8000000000000, 5'b00000, 4'd1},
      '{64'hBFF8000000000000, 64'h4000000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'hC008000000000000, 5'b00000, 4'd1},
      // R3 directed rounding of (1+ulp)^2
      '{64'h3FF0000000000001, 64'h3FF0000000000001, 2'd0, 1'b0, 2'd0, 1'b0, 64'h3FF0000000000002, 5'b10000, 4'd3},
      '{64'h3FF0000000000001, 64'h3FF0000000000001, 2'd2, 1'b0, 2'd0, 1'b0, 64'h3FF0000000000003, 5'b10000, 4'd3},
      '{64'h3FF0000000000001, 64'h3FF0000000000001, 2'd3, 1'b0, 2'd0, 1'b0, 64'h3FF0000000000002, 5'b10000, 4'd3},
      '{64'hBFF0000000000001, 64'h3FF0000000000001, 2'd1, 1'b0, 2'd0, 1'b0, 64'hBFF0000000000003, 5'b10000, 4'd3},
      '{64'hBFF0000000000001, 64'h3FF0000000000001, 2'd2, 1'b0, 2'd0, 1'b0, 64'hBFF0000000000002, 5'b10000, 4'd3},
      // R2 mode source selection
      '{64'h3FF0000000000001, 64'h3FF0000000000001, 2'd2, 1'b1, 2'd3, 1'b0, 64'h3FF0000000000003, 5'b10000, 4'd2},
      '{64'h3FF0000000000001, 64'h3FF0000000000001, 2'd2, 1'b1, 2'd3, 1'b1, 64'h3FF0000000000002, 5'b10000, 4'd2},
      '{64'h3FF0000000000001, 64'h3FF0000000000001, 2'd3, 1'b0, 2'd2, 1'b1, 64'h3FF0000000000002, 5'b10000, 4'd2},
      '{64'h3FF0000000000001, 64'h3FF0000000000001, 2'd3, 1'b1, 2'd2, 1'b1, 64'h3FF0000000000003, 5'b10000, 4'd2},
      // R4 overflow per mode and sign
      '{64'h7FE0000000000000, 64'h4000000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'h7FF0000000000000, 5'b10100, 4'd4},
      '{64'h7FE0000000000000, 64'h4000000000000000, 2'd3, 1'b0, 2'd0, 1'b0, 64'h7FEFFFFFFFFFFFFF, 5'b10100, 4'd4},
      '{64'hFFE0000000000000, 64'h4000000000000000, 2'd1, 1'b0, 2'd0, 1'b0, 64'hFFF0000000000000, 5'b10100, 4'd4},
      '{64'hFFE0000000000000, 64'h4000000000000000, 2'd2, 1'b0, 2'd0, 1'b0, 64'hFFEFFFFFFFFFFFFF, 5'b10100, 4'd4},
      '{64'h7FEFFFFFFFFFFFFF, 64'h3FF0000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'h7FEFFFFFFFFFFFFF, 5'b00000, 4'd4},
      // R5 subnormal results, exact and tie
      '{64'h0010000000000000, 64'h3FE0000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'h0008000000000000, 5'b00000, 4'd5},
      '{64'h0010000000000001, 64'h3FE0000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'h0008000000000000, 5'b11000, 4'd5},
      '{64'h0000000000000001, 64'h3FE0000000000000, 2'd2, 1'b0, 2'd0, 1'b0, 64'h0000000000000001, 5'b11010, 4'd5},
      // R8 denormal operand flag
      '{64'h0000000000000001, 64'h3FF0000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'h0000000000000001, 5'b00010, 4'd8},
      '{64'h0000000000000001, 64'h3FE0000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'h0000000000000000, 5'b11010, 4'd8},
      // R6 invalid cases and quiet NaN
      '{64'h0000000000000000, 64'h7FF0000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'hFFF8000000000000, 5'b00001, 4'd6},
      '{64'h7FF0000000000001, 64'h3FF0000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'h7FF8000000000001, 5'b00001, 4'd6},
      '{64'h7FF8000000000005, 64'h4000000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'h7FF8000000000005, 5'b00000, 4'd6},
      // R11 first NaN wins
      '{64'h7FF8000000000005, 64'h7FF0000000000001, 2'd0, 1'b0, 2'd0, 1'b0, 64'h7FF8000000000005, 5'b00001, 4'd11},
      '{64'h7FF0000000000009, 64'h7FF8000000000003, 2'd0, 1'b0, 2'd0, 1'b0, 64'h7FF8000000000009, 5'b00001, 4'd11},
      // R7 signs of zero and infinity
      '{64'h8000000000000000, 64'h4014000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'h8000000000000000, 5'b00000, 4'd7},
      '{64'h7FF0000000000000, 64'hC000000000000000, 2'd0, 1'b0, 2'd0, 1'b0, 64'hFFF0000000000000, 5'b00000, 4'd7}
   };

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp_v);
      n_checks++;
      if (act !== exp_v) begin
         n_errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp_v);
      end
   endtask

   task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] csr, input logic ovr,
                         input logic [1:0] orm, input logic breg);
      @(negedge clk);
      op_a = a; op_b = b; csr_rm = csr; rm_override_en = ovr;
      op_rm = orm; b_from_reg = breg; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [63:0] rand_op(input int emin, input int emax);
      logic [10:0] e;
      logic [51:0] f;
      e = 11'(emin + int'($urandom % 32'(emax - emin + 1)));
      f = {20'($urandom), $urandom};
      return {1'($urandom), e, f};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [63:0] exp_r;
      real ra, rb;
      repeat (3) @(negedge clk);
      // R10 outputs cleared while reset is held
      check("R10", "out_valid in reset", 64'(out_valid), 64'd0);
      check("R10", "result in reset", result, 64'd0);
      check("R10", "flags in reset", 64'(flags), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         run_op(VECS[i].a, VECS[i].b, VECS[i].csr, VECS[i].ovr, VECS[i].orm, VECS[i].breg);
         check($sformatf("R%0d", VECS[i].req), "result", result, VECS[i].exp_res);
         check($sformatf("R%0d", VECS[i].req), "flags", 64'(flags), 64'(VECS[i].exp_fl));
         check("R9", "out_valid one cycle after in_valid", 64'(out_valid), 64'd1);
      end

      // R9 idle cycle: valid drops, result and flags hold
      @(negedge clk);
      check("R9", "out_valid when idle", 64'(out_valid), 64'd0);
      check("R9", "result held", result, VECS[NV-1].exp_res);
      check("R9", "flags held", 64'(flags), 64'(VECS[NV-1].exp_fl));

      // R1 random normal operands, nearest-even reference
      for (int i = 0; i < 400; i++) begin
         logic [63:0] a, b;
         a = rand_op(1023 - 300, 1023 + 300);
         b = rand_op(1023 - 300, 1023 + 300);
         ra = $bitstoreal(a);
         rb = $bitstoreal(b);
         exp_r = $realtobits(ra * rb);
         run_op(a, b, 2'd0, 1'b0, 2'd0, 1'b0);
         check("R1", "random product", result, exp_r);
      end

      // R5 random products around the bottom of the normal range
      for (int i = 0; i < 400; i++) begin
         logic [63:0] a, b;
         a = rand_op(1023 - 560, 1023 - 480);
         b = rand_op(1023 - 560, 1023 - 480);
         ra = $bitstoreal(a);
         rb = $bitstoreal(b);
         exp_r = $realtobits(ra * rb);
         run_op(a, b, 2'd0, 1'b0, 2'd0, 1'b1);
         check("R5", "random tiny product", result, exp_r);
      end

      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule